// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether an instruction may take effect. It takes a 4-bit condition code and tests it against the four arithmetic flags held in a 32-bit status word. The 16 codes cover four groups: single-flag tests, unsigned comparisons, signed comparisons and an always-pass pair. A design that steps or predicts instruction flow uses the result as its execute or suppress decision. Alongside that decision, the block gives the sequential address to take when the instruction is suppressed.

The block handles two instruction widths. In wide (32-bit) mode, the code is the top nibble of the opcode and it governs every instruction. In narrow (16-bit) mode, the code is opcode bits 11:8 and it matters only for a conditional branch. The caller marks such a branch on a dedicated input, and any other narrow instruction always executes. An output register stage can be selected by parameter to help timing.

Top module: `cond_gate`

## Requirements
- R1: The flags are read from fixed status-word positions: N = bit 31, Z = bit 30, C = bit 29, V = bit 28. All other status bits have no effect on `exec_o`.
- R2: Codes 0 and 1 pass when Z is set and when Z is clear, respectively. Codes 2/3 do the same with C, codes 4/5 with N, and codes 6/7 with V.
- R3: Code 8 passes when C = 1 and Z = 0. Code 9 passes when C = 0 or Z = 1.
- R4: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R5: Code 12 passes when Z = 0 and N equals V. Code 13 passes when Z = 1 or N differs from V.
- R6: Codes 14 and 15 always pass, for any flag values.
- R7: In wide mode (`mode_i` = 0), the code is `opcode_i[31:28]` and `cond_o` reports it. The test applies whatever the value of `is_branch_i`, and `opcode_i[11:8]` has no effect.
- R8: In narrow mode (`mode_i` = 1), the code is `opcode_i[11:8]` and `cond_o` reports it. The test decides `exec_o` only when `is_branch_i` = 1. Otherwise `exec_o` = 1.
- R9: `fall_pc_o` equals `pc_i` + 4 in wide mode and `pc_i` + 2 in narrow mode, wrapping modulo 2^32.
- R10: With the output register enabled (the default), every output shows the result for the inputs that were present at the previous rising clock edge. While `rst_ni` is low, `exec_o`, `cond_o` and `fall_pc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = wide 32-bit opcode, 1 = narrow 16-bit opcode |
| opcode_i | input | 32 | Instruction word; a narrow opcode sits in bits 15:0 |
| is_branch_i | input | 1 | Narrow instruction is a conditional branch |
| status_i | input | 32 | Status word carrying N, Z, C, V |
| pc_i | input | 32 | Address of the instruction |
| exec_o | output | 1 | 1 = instruction takes effect, 0 = suppressed |
| cond_o | output | 4 | Condition code taken from the active field |
| fall_pc_o | output | 32 | Sequential next address (pc + instruction size) |

## Verification
The bound checker checks several rules on every cycle. It confirms that `cond_o` tracks the field chosen by the mode and that codes 14/15 and narrow non-branches always execute. It also checks the sequential address and, for one code from each group, that the decision matches the flags in the status word. The bench covers what the assertions cannot see: the reset values, the one-cycle delay of the output stage, and the full 16-code table under random and exhaustive flag patterns. It also shows that a field in the unused position, or a status bit outside the flag nibble, leaves the decision unchanged.

// File: rtl/cond_pkg.sv
`timescale 1ns/1ps
package cond_pkg;

  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } isa_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int unsigned CODE_W = 4;

  // Base predicate per code pair (code[3:1]); code[0] selects inversion
  typedef enum logic [2:0] {
    GRP_Z    = 3'd0,
    GRP_C    = 3'd1,
    GRP_N    = 3'd2,
    GRP_V    = 3'd3,
    GRP_UHI  = 3'd4,
    GRP_SGE  = 3'd5,
    GRP_SGT  = 3'd6,
    GRP_ALL  = 3'd7
  } cond_grp_e;

endpackage

// File: rtl/cond_field_pick.sv
`timescale 1ns/1ps
module cond_field_pick
  import cond_pkg::*;
#(
  parameter int unsigned OP_W       = 32,
  parameter int unsigned NARROW_LSB = 8
) (
  input  isa_mode_e           mode_i,
  input  logic [OP_W-1:0]     opcode_i,
  input  logic                is_branch_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                gated_o
);

  localparam int unsigned WIDE_LSB = OP_W - CODE_W;

  logic [CODE_W-1:0] wide_code, narrow_code;

  assign wide_code   = opcode_i[WIDE_LSB +: CODE_W];
  assign narrow_code = opcode_i[NARROW_LSB +: CODE_W];

  always_comb begin
    unique case (mode_i)
      MODE_WIDE: begin
        code_o  = wide_code;
        gated_o = 1'b1;
      end
      default: begin
        code_o  = narrow_code;
        gated_o = is_branch_i;  // narrow: only branches are conditional
      end
    endcase
  end

  logic unused_op_bits;
  assign unused_op_bits = ^{opcode_i[WIDE_LSB-1:NARROW_LSB+CODE_W], opcode_i[NARROW_LSB-1:0]};

endmodule

// File: rtl/cond_flag_eval.sv
`timescale 1ns/1ps
module cond_flag_eval
  import cond_pkg::*;
(
  input  flags_t              flags_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic                pass_o
);

  localparam int unsigned N_CODES = 1 << CODE_W;
  localparam int unsigned N_GRPS  = N_CODES / 2;

  logic [N_CODES-1:0] pass_vec;
  logic               sgn_eq;

  assign sgn_eq = (flags_i.n == flags_i.v);

  for (genvar g = 0; g < N_GRPS; g++) begin : g_grp
    logic base;
    always_comb begin
      unique case (cond_grp_e'(g))
        GRP_Z:   base = flags_i.z;
        GRP_C:   base = flags_i.c;
        GRP_N:   base = flags_i.n;
        GRP_V:   base = flags_i.v;
        GRP_UHI: base = flags_i.c & ~flags_i.z;
        GRP_SGE: base = sgn_eq;
        GRP_SGT: base = ~flags_i.z & sgn_eq;
        default: base = 1'b1;
      endcase
    end
    assign pass_vec[2*g] = base;
    if (g == N_GRPS - 1) begin : g_always
      assign pass_vec[2*g+1] = 1'b1;
    end else begin : g_inv
      assign pass_vec[2*g+1] = ~base;
    end
  end

  assign pass_o = pass_vec[code_i];

endmodule

// File: rtl/cond_next_pc.sv
`timescale 1ns/1ps
module cond_next_pc
  import cond_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WIDE_BYTES = 4
) (
  input  isa_mode_e           mode_i,
  input  logic [ADDR_W-1:0]   pc_i,
  output logic [ADDR_W-1:0]   next_o
);

  localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(WIDE_BYTES);
  localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(WIDE_BYTES / 2);

  assign next_o = pc_i + ((mode_i == MODE_NARROW) ? STEP_NARROW : STEP_WIDE);

endmodule

// File: rtl/cond_gate.sv
`timescale 1ns/1ps
module cond_gate
  import cond_pkg::*;
#(
  parameter int unsigned OP_W    = 32,
  parameter int unsigned ST_W    = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic [OP_W-1:0]     opcode_i,
  input  logic                is_branch_i,
  input  logic [ST_W-1:0]     status_i,
  input  logic [ADDR_W-1:0]   pc_i,
  output logic                exec_o,
  output logic [CODE_W-1:0]   cond_o,
  output logic [ADDR_W-1:0]   fall_pc_o
);

  localparam int unsigned FLAG_LSB = ST_W - 4;

  isa_mode_e         mode;
  flags_t            flags;
  logic [CODE_W-1:0] code_d;
  logic              gated, pass;
  logic              exec_d;
  logic [ADDR_W-1:0] next_d;

  assign mode  = isa_mode_e'(mode_i);
  assign flags = flags_t'(status_i[FLAG_LSB +: 4]);

  logic unused_status;
  assign unused_status = ^status_i[FLAG_LSB-1:0];

  cond_field_pick #(.OP_W(OP_W)) i_pick (
    .mode_i      (mode),
    .opcode_i    (opcode_i),
    .is_branch_i (is_branch_i),
    .code_o      (code_d),
    .gated_o     (gated)
  );

  cond_flag_eval i_eval (
    .flags_i (flags),
    .code_i  (code_d),
    .pass_o  (pass)
  );

  cond_next_pc #(.ADDR_W(ADDR_W)) i_npc (
    .mode_i (mode),
    .pc_i   (pc_i),
    .next_o (next_d)
  );

  assign exec_d = ~gated | pass;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        exec_o    <= 1'b0;
        cond_o    <= '0;
        fall_pc_o <= '0;
      end else begin
        exec_o    <= exec_d;
        cond_o    <= code_d;
        fall_pc_o <= next_d;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign exec_o    = exec_d;
    assign cond_o    = code_d;
    assign fall_pc_o = next_d;
  end

endmodule

// File: rtl/cond_gate_chk.sv
`timescale 1ns/1ps
module cond_gate_chk #(
  parameter int unsigned OP_W    = 32,
  parameter int unsigned ST_W    = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic [OP_W-1:0]   opcode_i,
  input logic              is_branch_i,
  input logic [ST_W-1:0]   status_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              exec_o,
  input logic [3:0]        cond_o,
  input logic [ADDR_W-1:0] fall_pc_o
);

  logic              mode_a, br_a, seen;
  logic [OP_W-1:0]   op_a;
  logic [ST_W-1:0]   st_a;
  logic [ADDR_W-1:0] pc_a;

  // Inputs aligned with the output stage
  if (REG_OUT) begin : g_align
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_a <= 1'b0; br_a <= 1'b0; op_a <= '0; st_a <= '0; pc_a <= '0; seen <= 1'b0;
      end else begin
        mode_a <= mode_i; br_a <= is_branch_i; op_a <= opcode_i;
        st_a <= status_i; pc_a <= pc_i; seen <= 1'b1;
      end
    end
  end else begin : g_direct
    assign mode_a = mode_i;
    assign br_a   = is_branch_i;
    assign op_a   = opcode_i;
    assign st_a   = status_i;
    assign pc_a   = pc_i;
    assign seen   = 1'b1;
  end

  logic       fn, fz, fc, fv;
  logic [3:0] wide_f, narrow_f;
  assign fn = st_a[ST_W-1];
  assign fz = st_a[ST_W-2];
  assign fc = st_a[ST_W-3];
  assign fv = st_a[ST_W-4];
  assign wide_f   = op_a[OP_W-1 -: 4];
  assign narrow_f = op_a[11:8];

  logic unused_chk;
  assign unused_chk = ^{op_a[OP_W-5:12], op_a[7:0], st_a[ST_W-5:0]};

  logic wide_tst;
  assign wide_tst = seen && !mode_a;

  a_r2_eq_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_tst && wide_f == 4'h0) |-> (exec_o == fz));
  a_r1_ne_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_tst && wide_f == 4'h1) |-> (exec_o == !fz));
  a_r3_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_tst && wide_f == 4'h8) |-> (exec_o == (fc && !fz)));
  a_r4_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_tst && wide_f == 4'hA) |-> (exec_o == (fn == fv)));
  a_r5_le: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_tst && wide_f == 4'hD) |-> (exec_o == (fz || (fn != fv))));
  a_r6_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && cond_o[3:1] == 3'b111) |-> exec_o);
  a_r7_wide_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_tst |-> (cond_o == wide_f));
  a_r8_narrow_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && mode_a) |-> (cond_o == narrow_f));
  a_r8_nonbranch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && mode_a && !br_a) |-> exec_o);
  a_r9_fall_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (fall_pc_o == pc_a + (mode_a ? ADDR_W'(2) : ADDR_W'(4))));

endmodule

bind cond_gate cond_gate_chk #(
  .OP_W(OP_W), .ST_W(ST_W), .ADDR_W(ADDR_W), .REG_OUT(REG_OUT)
) i_cond_gate_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .opcode_i    (opcode_i),
  .is_branch_i (is_branch_i),
  .status_i    (status_i),
  .pc_i        (pc_i),
  .exec_o      (exec_o),
  .cond_o      (cond_o),
  .fall_pc_o   (fall_pc_o)
);

// File: tb/test_cond_gate.sv
`timescale 1ns/1ps
module test_cond_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] opcode = '0;
  logic        is_br = 1'b0;
  logic [31:0] status = '0;
  logic [31:0] pc = '0;
  logic        exec_o;
  logic [3:0]  cond_o;
  logic [31:0] fall_pc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cond_gate i_cond_gate (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .opcode_i(opcode),
    .is_branch_i(is_br), .status_i(status), .pc_i(pc),
    .exec_o(exec_o), .cond_o(cond_o), .fall_pc_o(fall_pc_o)
  );

  function automatic bit ref_cond(logic [3:0] c, logic [31:0] st);
    bit n, z, cy, v;
    n = st[31]; z = st[30]; cy = st[29]; v = st[28];
    case (c)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return cy;
      4'h3: return !cy;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return cy && !z;
      4'h9: return !cy || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] ref_field(logic m, logic [31:0] op);
    return m ? op[11:8] : op[31:28];
  endfunction

  function automatic bit ref_exec(logic m, logic [31:0] op, logic br, logic [31:0] st);
    if (m && !br) return 1'b1;
    return ref_cond(ref_field(m, op), st);
  endfunction

  function automatic string req_of(logic [3:0] c);
    if (c < 4'h8) return "R2";
    if (c < 4'hA) return "R3";
    if (c < 4'hC) return "R4";
    if (c < 4'hE) return "R5";
    return "R6";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one rising edge between)
  task automatic apply(logic m, logic [31:0] op, logic br, logic [31:0] st, logic [31:0] p);
    mode = m; opcode = op; is_br = br; status = st; pc = p;
    @(negedge clk);
  endtask

  task automatic check_all(string exec_req);
    chk(exec_req, 32'(exec_o), 32'(ref_exec(mode, opcode, is_br, status)));
    chk(mode ? "R8" : "R7", 32'(cond_o), 32'(ref_field(mode, opcode)));
    chk("R9", fall_pc_o, pc + (mode ? 32'd2 : 32'd4));
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10", 32'(exec_o), 0);
    chk("R10", 32'(cond_o), 0);
    chk("R10", fall_pc_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2..R6: every code against all 16 flag patterns, wide mode
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply(1'b0, {4'(c), 28'h0123456}, 1'b0, {4'(f), 28'h0}, 32'h100);
        chk(req_of(4'(c)), 32'(exec_o), 32'(ref_cond(4'(c), {4'(f), 28'h0})));
      end
    end

    // R1: non-flag status bits set, all flags clear -> EQ fails, NE passes
    apply(1'b0, 32'h0000_0000, 1'b0, 32'h0FFF_FFFF, 32'h0);
    chk("R1", 32'(exec_o), 0);
    apply(1'b0, 32'h1000_0000, 1'b0, 32'h0FFF_FFFF, 32'h0);
    chk("R1", 32'(exec_o), 1);
    apply(1'b0, 32'h0000_0000, 1'b0, 32'h4000_0000, 32'h0);
    chk("R1", 32'(exec_o), 1);

    // R7: wide field only, is_branch ignored, bits 11:8 have no effect
    apply(1'b0, 32'h0000_0E00, 1'b0, 32'h0, 32'h20);
    chk("R7", 32'(exec_o), 0);
    chk("R7", 32'(cond_o), 0);
    apply(1'b0, 32'h0000_0E00, 1'b1, 32'h0, 32'h20);
    chk("R7", 32'(exec_o), 0);

    // R8: narrow field, branch gated, non-branch always executes
    apply(1'b1, 32'hE000_0000, 1'b1, 32'h0, 32'h40);
    chk("R8", 32'(exec_o), 0);
    chk("R8", 32'(cond_o), 0);
    apply(1'b1, 32'h0000_0000, 1'b0, 32'h0, 32'h40);
    chk("R8", 32'(exec_o), 1);
    apply(1'b1, 32'h0000_0100, 1'b1, 32'h0, 32'h40);
    chk("R8", 32'(exec_o), 1);

    // R9: wrap-around
    apply(1'b0, 32'hE000_0000, 1'b0, 32'h0, 32'hFFFF_FFFE);
    chk("R9", fall_pc_o, 32'h0000_0002);
    apply(1'b1, 32'h0, 1'b0, 32'h0, 32'hFFFF_FFFF);
    chk("R9", fall_pc_o, 32'h0000_0001);

    // R10: one-cycle latency: old value held until the rising edge
    apply(1'b0, 32'hE000_0000, 1'b0, 32'h0, 32'h200);
    mode = 1'b0; opcode = 32'h0000_0000; status = 32'h0; pc = 32'h300;
    #1;
    chk("R10", 32'(exec_o), 1);
    chk("R10", fall_pc_o, 32'h204);
    @(negedge clk);
    chk("R10", 32'(exec_o), 0);
    chk("R10", fall_pc_o, 32'h304);

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      logic m, b;
      logic [31:0] op;
      m  = 1'($urandom);
      b  = 1'($urandom);
      op = $urandom;
      apply(m, op, b, $urandom, $urandom);
      check_all((m && !b) ? "R8" : req_of(ref_field(m, op)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule